// File: doc/BRIEF.md
# Address-Range Monitor Wait Controller

This block sequences a processor core's monitor-and-wait facility. A monitor request records one 64-byte aligned line of the address space as the watched range. A later wait instruction halts the core in a low-activity state, signalled by `asleep_o`. The core stays halted until a qualifying event arrives. That event may be a snooped store into the watched line, an unmaskable event, or an ordinary interrupt if interrupts were enabled when the wait was issued. On exit, the block pulses `resume_o` for one cycle so the core continues at the instruction after the wait. In the same cycle it reports a 3-bit wake cause.

The wait request is recognised only from an exact three-byte opcode. Several checks run before the wait is allowed. A cleared global enable hides the feature flag and turns every wait into an illegal-opcode fault. A non-zero privilege level needs a separate permission input. When reserved checking is on, a non-zero hint or extension operand is rejected.

If the watched line is hit, or an unmaskable event arrives, between arming and the wait, that event is remembered. The following wait then returns at once. A wait with nothing armed also returns at once.

Top module: `addr_monitor_wait`

## Requirements
- R1: `feature_o` equals `global_en_i` in every cycle.
- R2: A wait is recognised only when `op_valid_i` is high and `op_bytes_i` equals 24'h0F01C9 (bits [23:16]=0F, [15:8]=01, [7:0]=C9). Any other byte pattern causes no fault, no sleep and no resume.
- R3: A recognised wait faults if any of these holds: `global_en_i` is 0; `cpl_i` is non-zero while `user_wait_ok_i` is 0; `rsvd_mode_i` is 1 while `hint_i` or `ext_i` is non-zero. The fault is a one-cycle `fault_ud_o` pulse in the next cycle, and the core neither sleeps nor resumes.
- R4: A monitor request arms the line `mon_addr_i[ADDR_W-1:6]`. While asleep, a snooped store whose bits [ADDR_W-1:6] match that line wakes the core with cause 0. A store to any other line has no effect.
- R5: While asleep, `intr_i` wakes the core with cause 1 only if `intr_en_i` was 1 in the cycle the wait was issued. Otherwise it is ignored.
- R6: While asleep, each of these wakes the core whatever the interrupt flag: NMI (cause 2), SMI (3), debug (4), machine check (5), INIT or BINIT (6), reset event (7).
- R7: When several wake events occur in the same cycle, the highest cause code wins.
- R8: After arming and before a wait, a matching store or an unmaskable event is remembered with its cause. The next legal wait then resumes in the next cycle with that cause and zero asleep cycles. Interrupts seen before the wait are not remembered.
- R9: A legal wait with nothing armed resumes in the next cycle with cause 0.
- R10: Every exit from a wait (immediate or after sleeping) disarms the line, so a following wait without a new monitor returns at once.
- R11: After reset, `asleep_o`, `resume_o`, `fault_ud_o` are 0 and the cause is 0. `asleep_o` rises the cycle after a sleeping wait is issued. On a wake event, the next cycle shows `asleep_o` low and a one-cycle `resume_o`. The cause holds until the next resume.
- R12: While asleep, monitor requests and wait requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| global_en_i | input | 1 | Global feature enable |
| cpl_i | input | 2 | Current privilege level |
| user_wait_ok_i | input | 1 | Permits waits at levels 1 to 3 |
| rsvd_mode_i | input | 1 | Treat non-zero hint or extension as a fault |
| mon_valid_i | input | 1 | Monitor request |
| mon_addr_i | input | ADDR_W | Address to arm |
| op_valid_i | input | 1 | Instruction presented |
| op_bytes_i | input | 24 | Instruction opcode bytes |
| hint_i | input | HINT_W | Preferred sleep state operand |
| ext_i | input | EXT_W | Extension options operand |
| intr_en_i | input | 1 | Interrupt-enable flag at issue |
| snoop_valid_i | input | 1 | Snooped store present |
| snoop_addr_i | input | ADDR_W | Snooped store address |
| intr_i | input | 1 | Maskable interrupt |
| nmi_i | input | 1 | Non-maskable interrupt |
| smi_i | input | 1 | System management interrupt |
| dbg_i | input | 1 | Debug exception |
| mchk_i | input | 1 | Machine-check exception |
| init_i | input | 1 | INIT event |
| binit_i | input | 1 | BINIT event |
| reset_evt_i | input | 1 | Reset event |
| asleep_o | output | 1 | Core held in wait |
| wake_cause_o | output | 3 | Cause of the last exit |
| resume_o | output | 1 | Continue at next instruction |
| fault_ud_o | output | 1 | Illegal-opcode fault |
| feature_o | output | 1 | Feature-present flag |

## Verification
Two paths can fall in the same cycle: the wait issue and the arrival of wake events. A wake event on the issue cycle, or one stored before it, must end the wait at once. A wake event one cycle later must come after exactly one asleep cycle. The bench provokes these by firing stores, interrupts and unmaskable events on, before and after the issue cycle, and by stacking several event lines in one cycle. A behavioural reference model judges the asleep, resume, cause and fault outputs on every clock. It settles priority by scanning the event codes from the top.

// File: rtl/amw_pkg.sv
package amw_pkg;
  typedef enum logic [2:0] {
    CAUSE_STORE = 3'd0,
    CAUSE_INTR  = 3'd1,
    CAUSE_NMI   = 3'd2,
    CAUSE_SMI   = 3'd3,
    CAUSE_DEBUG = 3'd4,
    CAUSE_MCHK  = 3'd5,
    CAUSE_INIT  = 3'd6,
    CAUSE_RESET = 3'd7
  } wake_cause_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } wait_state_e;

  localparam int unsigned NUM_CAUSES = 8;
  localparam int unsigned CAUSE_W    = 3;
  localparam int unsigned OPC_BYTES  = 3;
  localparam logic [23:0] WAIT_OPCODE = 24'h0F01C9;
endpackage

// File: rtl/amw_wait_decode.sv
module amw_wait_decode
  import amw_pkg::*;
#(
  parameter int unsigned HINT_W = 32,
  parameter int unsigned EXT_W  = 32
) (
  input  logic              op_valid_i,
  input  logic [23:0]       op_bytes_i,
  input  logic              accept_i,
  input  logic              global_en_i,
  input  logic [1:0]        cpl_i,
  input  logic              user_ok_i,
  input  logic              rsvd_mode_i,
  input  logic [HINT_W-1:0] hint_i,
  input  logic [EXT_W-1:0]  ext_i,
  output logic              wait_go_o,
  output logic              wait_fault_o
);
  logic [OPC_BYTES-1:0] byte_hit;
  logic                 opcode_hit;
  logic                 priv_bad;
  logic                 rsvd_bad;
  logic                 illegal;

  for (genvar b = 0; b < OPC_BYTES; b++) begin : g_byte
    assign byte_hit[b] = (op_bytes_i[8*b +: 8] == WAIT_OPCODE[8*b +: 8]);
  end

  always_comb begin
    opcode_hit   = op_valid_i && accept_i && (&byte_hit);
    priv_bad     = (cpl_i != 2'd0) && !user_ok_i;
    rsvd_bad     = rsvd_mode_i && ((|hint_i) || (|ext_i));
    illegal      = !global_en_i || priv_bad || rsvd_bad;
    wait_go_o    = opcode_hit && !illegal;
    wait_fault_o = opcode_hit && illegal;
  end
endmodule

// File: rtl/amw_line_tracker.sv
module amw_line_tracker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              armed_o,
  output logic              hit_o
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;

  logic             armed_q, armed_d;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] arm_tag;
  logic [TAG_W-1:0] snoop_tag;

  always_comb begin
    arm_tag   = TAG_W'(addr_i >> OFF_W);
    snoop_tag = TAG_W'(snoop_addr_i >> OFF_W);
    armed_d   = armed_q;
    if (arm_i) begin
      armed_d = 1'b1;
    end else if (clear_i) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
    end else if (arm_i) begin
      tag_q <= arm_tag;
    end
  end

  assign armed_o = armed_q;
  assign hit_o   = snoop_valid_i && armed_q && (snoop_tag == tag_q);

  assert_arm_needs_request_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(arm_i));
  assert_clear_disarms_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !arm_i) |=> !armed_q);
endmodule

// File: rtl/amw_wake_prio.sv
module amw_wake_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = $clog2(N)
) (
  input  logic [N-1:0]  ev_i,
  output logic          any_o,
  output logic [CW-1:0] cause_o
);
  always_comb begin
    any_o   = 1'b0;
    cause_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (ev_i[i]) begin
        any_o   = 1'b1;
        cause_o = CW'(i);
      end
    end
  end
endmodule

// File: rtl/addr_monitor_wait.sv
module addr_monitor_wait
  import amw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned HINT_W     = 32,
  parameter int unsigned EXT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              global_en_i,
  input  logic [1:0]        cpl_i,
  input  logic              user_wait_ok_i,
  input  logic              rsvd_mode_i,
  input  logic              mon_valid_i,
  input  logic [ADDR_W-1:0] mon_addr_i,
  input  logic              op_valid_i,
  input  logic [23:0]       op_bytes_i,
  input  logic [HINT_W-1:0] hint_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic              intr_en_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              intr_i,
  input  logic              nmi_i,
  input  logic              smi_i,
  input  logic              dbg_i,
  input  logic              mchk_i,
  input  logic              init_i,
  input  logic              binit_i,
  input  logic              reset_evt_i,
  output logic              asleep_o,
  output logic [2:0]        wake_cause_o,
  output logic              resume_o,
  output logic              fault_ud_o,
  output logic              feature_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  wait_state_e          state_q, state_d;
  logic                 ie_q, ie_d;
  logic                 trig_q, trig_d;
  logic [CAUSE_W-1:0]   tcause_q, tcause_d;
  logic [CAUSE_W-1:0]   cause_q, cause_d;
  logic                 resume_q, resume_d;
  logic                 fault_q;
  logic                 wait_go, wait_fault;
  logic                 arm_set, arm_clr;
  logic                 armed, snoop_hit;
  logic                 ie_eff;
  logic [NUM_CAUSES-1:0] ev_vec;
  logic                 ev_any;
  logic [CAUSE_W-1:0]   ev_cause;

  amw_wait_decode #(.HINT_W(HINT_W), .EXT_W(EXT_W)) u_decode (
    .op_valid_i   (op_valid_i),
    .op_bytes_i   (op_bytes_i),
    .accept_i     (state_q == ST_RUN),
    .global_en_i  (global_en_i),
    .cpl_i        (cpl_i),
    .user_ok_i    (user_wait_ok_i),
    .rsvd_mode_i  (rsvd_mode_i),
    .hint_i       (hint_i),
    .ext_i        (ext_i),
    .wait_go_o    (wait_go),
    .wait_fault_o (wait_fault)
  );

  amw_line_tracker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_line (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .arm_i         (arm_set),
    .clear_i       (arm_clr),
    .addr_i        (mon_addr_i),
    .snoop_valid_i (snoop_valid_i),
    .snoop_addr_i  (snoop_addr_i),
    .armed_o       (armed),
    .hit_o         (snoop_hit)
  );

  always_comb begin
    ie_eff = (state_q == ST_SLEEP) ? ie_q : (wait_go && intr_en_i);
    ev_vec[CAUSE_STORE] = snoop_hit;
    ev_vec[CAUSE_INTR]  = intr_i && ie_eff;
    ev_vec[CAUSE_NMI]   = nmi_i;
    ev_vec[CAUSE_SMI]   = smi_i;
    ev_vec[CAUSE_DEBUG] = dbg_i;
    ev_vec[CAUSE_MCHK]  = mchk_i;
    ev_vec[CAUSE_INIT]  = init_i || binit_i;
    ev_vec[CAUSE_RESET] = reset_evt_i;
  end

  amw_wake_prio #(.N(NUM_CAUSES), .CW(CAUSE_W)) u_prio (
    .ev_i    (ev_vec),
    .any_o   (ev_any),
    .cause_o (ev_cause)
  );

  always_comb begin
    state_d  = state_q;
    ie_d     = ie_q;
    trig_d   = trig_q;
    tcause_d = tcause_q;
    cause_d  = cause_q;
    resume_d = 1'b0;
    arm_set  = 1'b0;
    arm_clr  = 1'b0;
    unique case (state_q)
      ST_SLEEP: begin
        if (ev_any) begin
          state_d  = ST_RUN;
          resume_d = 1'b1;
          cause_d  = ev_cause;
          arm_clr  = 1'b1;
          trig_d   = 1'b0;
        end
      end
      ST_RUN: begin
        if (wait_go) begin
          if (!armed) begin
            resume_d = 1'b1;
            cause_d  = CAUSE_STORE;
          end else if (trig_q) begin
            resume_d = 1'b1;
            cause_d  = tcause_q;
            arm_clr  = 1'b1;
            trig_d   = 1'b0;
          end else if (ev_any) begin
            resume_d = 1'b1;
            cause_d  = ev_cause;
            arm_clr  = 1'b1;
          end else begin
            state_d = ST_SLEEP;
            ie_d    = intr_en_i;
          end
        end else if (mon_valid_i) begin
          arm_set = 1'b1;
          trig_d  = 1'b0;
        end else if (armed && !trig_q && ev_any) begin
          trig_d   = 1'b1;
          tcause_d = ev_cause;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      ie_q     <= 1'b0;
      trig_q   <= 1'b0;
      tcause_q <= '0;
      resume_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume_d;
      fault_q  <= wait_fault;
      trig_q   <= trig_d;
      if (state_q == ST_RUN && wait_go) begin
        ie_q <= ie_d;
      end
      if (trig_d && !trig_q) begin
        tcause_q <= tcause_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (resume_d) begin
      cause_q <= cause_d;
    end
  end

  assign asleep_o     = (state_q == ST_SLEEP);
  assign resume_o     = resume_q;
  assign wake_cause_o = cause_q;
  assign fault_ud_o   = fault_q;
  assign feature_o    = global_en_i;

  assert_fault_not_resume_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(fault_ud_o && resume_o));
  assert_disabled_faults_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!asleep_o && op_valid_i && op_bytes_i == WAIT_OPCODE && !global_en_i) |=> fault_ud_o);
  assert_exit_pulses_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(asleep_o) |-> resume_o);
  assert_masked_intr_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (asleep_o && !ie_q && !snoop_hit && !nmi_i && !smi_i && !dbg_i && !mchk_i &&
     !init_i && !binit_i && !reset_evt_i) |=> asleep_o);
  assert_reset_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (asleep_o && reset_evt_i) |=> (resume_o && wake_cause_o == CAUSE_RESET));
  assert_prio_pick_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    ev_any |-> ev_vec[ev_cause]);
endmodule

// File: tb/tb_addr_monitor_wait.sv
module tb_addr_monitor_wait;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int OFF = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic global_en, user_ok, rsvd_mode, mon_valid, op_valid, intr_en, snoop_valid;
  logic [1:0] cpl;
  logic [ADDR_W-1:0] mon_addr, snoop_addr;
  logic [23:0] op_bytes;
  logic [31:0] hint, ext;
  logic intr, nmi, smi, dbg, mchk, init, binit, reset_evt;
  logic asleep, resume, fault, feature;
  logic [2:0] cause;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_monitor_wait dut (
    .clk_i(clk), .rst_ni(rst_n), .global_en_i(global_en), .cpl_i(cpl),
    .user_wait_ok_i(user_ok), .rsvd_mode_i(rsvd_mode), .mon_valid_i(mon_valid),
    .mon_addr_i(mon_addr), .op_valid_i(op_valid), .op_bytes_i(op_bytes),
    .hint_i(hint), .ext_i(ext), .intr_en_i(intr_en), .snoop_valid_i(snoop_valid),
    .snoop_addr_i(snoop_addr), .intr_i(intr), .nmi_i(nmi), .smi_i(smi), .dbg_i(dbg),
    .mchk_i(mchk), .init_i(init), .binit_i(binit), .reset_evt_i(reset_evt),
    .asleep_o(asleep), .wake_cause_o(cause), .resume_o(resume), .fault_ud_o(fault),
    .feature_o(feature)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: state kept in plain variables, updated each rising edge.
  bit m_sleep, m_armed, m_trig, m_ie, e_res, e_fault;
  int m_tc, e_cause;
  logic [ADDR_W-1:0] m_line;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sleep = 0; m_armed = 0; m_trig = 0; m_ie = 0; m_tc = 0; m_line = '0;
      e_res = 0; e_fault = 0; e_cause = 0;
    end else begin
      bit go, hit, ie, any;
      bit [7:0] ev;
      int c;
      go = 0; e_res = 0; e_fault = 0;
      if (!m_sleep && op_valid && op_bytes == 24'h0F01C9) begin
        if (!global_en || (cpl != 0 && !user_ok) || (rsvd_mode && (hint != 0 || ext != 0)))
          e_fault = 1;
        else
          go = 1;
      end
      hit = snoop_valid && m_armed && ((snoop_addr >> OFF) == m_line);
      ie = m_sleep ? m_ie : (go && intr_en);
      ev = {reset_evt, init | binit, mchk, dbg, smi, nmi, intr & ie, hit};
      any = 0; c = 0;
      for (int k = 7; k >= 0; k--) if (ev[k] && !any) begin any = 1; c = k; end
      if (m_sleep) begin
        if (any) begin m_sleep = 0; e_res = 1; e_cause = c; m_armed = 0; m_trig = 0; end
      end else if (go) begin
        if (!m_armed) begin e_res = 1; e_cause = 0; end
        else if (m_trig) begin e_res = 1; e_cause = m_tc; m_armed = 0; m_trig = 0; end
        else if (any) begin e_res = 1; e_cause = c; m_armed = 0; end
        else begin m_sleep = 1; m_ie = intr_en; end
      end else if (mon_valid) begin
        m_armed = 1; m_trig = 0; m_line = mon_addr >> OFF;
      end else if (m_armed && !m_trig && any) begin
        m_trig = 1; m_tc = c;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 asleep vs model", int'(asleep), int'(m_sleep));
      chk("R11 resume vs model", int'(resume), int'(e_res));
      chk("R7 cause vs model", int'(cause), e_cause);
      chk("R3 fault vs model", int'(fault), int'(e_fault));
    end
  end

  task automatic idle();
    mon_valid = 0; op_valid = 0; snoop_valid = 0; intr = 0; nmi = 0; smi = 0;
    dbg = 0; mchk = 0; init = 0; binit = 0; reset_evt = 0; hint = 0; ext = 0;
    op_bytes = 24'h0F01C9; cpl = 0; user_ok = 0; rsvd_mode = 0; intr_en = 0;
    global_en = 1; mon_addr = '0; snoop_addr = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_mon(logic [ADDR_W-1:0] a);
    mon_valid = 1; mon_addr = a; cyc(); mon_valid = 0;
  endtask

  task automatic do_wait(bit ie);
    op_valid = 1; intr_en = ie; cyc(); op_valid = 0; intr_en = 0;
  endtask

  task automatic do_snoop(logic [ADDR_W-1:0] a);
    snoop_valid = 1; snoop_addr = a; cyc(); snoop_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [ADDR_W-1:0] LA = 32'h1234_5678;

  initial begin
    idle();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    repeat (3) cyc();
    chk("R11 reset asleep", int'(asleep), 0);
    chk("R11 reset resume", int'(resume), 0);
    chk("R11 reset fault", int'(fault), 0);
    chk("R11 reset cause", int'(cause), 0);
    chk("R1 feature on", int'(feature), 1);
    global_en = 0; #1;
    chk("R1 feature off", int'(feature), 0);
    global_en = 1; cyc();

    do_wait(0);
    chk("R9 unarmed resume", int'(resume), 1);
    chk("R9 unarmed cause", int'(cause), 0);
    chk("R9 no sleep", int'(asleep), 0);

    op_bytes = 24'h0F01C8; do_wait(0); op_bytes = 24'h0F01C9;
    chk("R2 wrong opcode sleep", int'(asleep), 0);
    chk("R2 wrong opcode resume", int'(resume), 0);
    chk("R2 wrong opcode fault", int'(fault), 0);

    global_en = 0; do_wait(0); global_en = 1;
    chk("R3 disabled fault", int'(fault), 1);
    cpl = 2; do_wait(0);
    chk("R3 privilege fault", int'(fault), 1);
    cpl = 3; user_ok = 1; do_wait(0); cpl = 0; user_ok = 0;
    chk("R3 permitted no fault", int'(fault), 0);
    chk("R3 permitted resume", int'(resume), 1);
    rsvd_mode = 1; hint = 5; do_wait(0);
    chk("R3 reserved hint fault", int'(fault), 1);
    rsvd_mode = 0; do_wait(0); hint = 0;
    chk("R3 hint allowed", int'(fault), 0);

    do_mon(LA); do_wait(0);
    chk("R4 asleep", int'(asleep), 1);
    do_snoop(32'h1234_5680);
    chk("R4 other line ignored", int'(asleep), 1);
    do_snoop(32'h1234_567C);
    chk("R4 line hit wake", int'(resume), 1);
    chk("R4 store cause", int'(cause), 0);
    chk("R11 awake after hit", int'(asleep), 0);
    do_wait(0);
    chk("R10 disarmed returns", int'(resume), 1);
    chk("R10 no sleep", int'(asleep), 0);

    do_mon(LA); do_wait(0);
    intr = 1; cyc(); cyc(); intr = 0;
    chk("R5 masked interrupt", int'(asleep), 1);
    nmi = 1; cyc(); nmi = 0;
    chk("R6 nmi cause", int'(cause), 2);
    do_mon(LA); do_wait(1);
    intr = 1; cyc(); intr = 0;
    chk("R5 enabled interrupt", int'(cause), 1);

    do_mon(LA); do_wait(0);
    mchk = 1; smi = 1; intr = 1; snoop_valid = 1; snoop_addr = LA; cyc(); idle();
    chk("R7 mchk over others", int'(cause), 5);
    do_mon(LA); do_wait(0);
    reset_evt = 1; init = 1; mchk = 1; dbg = 1; smi = 1; nmi = 1; cyc(); idle();
    chk("R7 reset highest", int'(cause), 7);
    do_mon(LA); do_wait(0);
    binit = 1; cyc(); idle();
    chk("R6 binit cause", int'(cause), 6);

    do_mon(LA); do_wait(0);
    do_mon(32'h0000_4000);
    do_snoop(32'h0000_4000);
    chk("R12 monitor ignored", int'(asleep), 1);
    do_wait(0);
    chk("R12 wait ignored", int'(resume), 0);
    dbg = 1; cyc(); dbg = 0;
    chk("R6 debug cause", int'(cause), 4);

    do_mon(LA); do_snoop(LA); do_wait(0);
    chk("R8 early store resume", int'(resume), 1);
    chk("R8 early store no sleep", int'(asleep), 0);
    do_mon(LA); smi = 1; cyc(); smi = 0; do_wait(0);
    chk("R8 early smi cause", int'(cause), 3);
    do_mon(LA); intr = 1; cyc(); intr = 0; do_wait(1);
    chk("R8 early interrupt dropped", int'(asleep), 1);
    nmi = 1; cyc(); nmi = 0;
    chk("R8 later nmi", int'(cause), 2);

    for (int i = 0; i < 4000; i++) begin
      global_en   = ($urandom % 16) != 0;
      cpl         = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
      user_ok     = 1'($urandom);
      rsvd_mode   = 1'($urandom);
      hint        = (($urandom % 8) == 0) ? 32'($urandom % 3) : 32'd0;
      ext         = (($urandom % 8) == 0) ? 32'd1 : 32'd0;
      mon_valid   = ($urandom % 6) == 0;
      mon_addr    = {26'(($urandom % 3) + 4), 6'($urandom)};
      op_valid    = ($urandom % 5) == 0;
      op_bytes    = (($urandom % 8) == 0) ? 24'h0F01C8 : 24'h0F01C9;
      intr_en     = 1'($urandom);
      snoop_valid = ($urandom % 4) == 0;
      snoop_addr  = {26'(($urandom % 3) + 4), 6'($urandom)};
      intr        = ($urandom % 6) == 0;
      nmi         = ($urandom % 30) == 0;
      smi         = ($urandom % 30) == 0;
      dbg         = ($urandom % 30) == 0;
      mchk        = ($urandom % 30) == 0;
      init        = ($urandom % 40) == 0;
      binit       = ($urandom % 40) == 0;
      reset_evt   = ($urandom % 40) == 0;
      cyc();
    end
    idle();
    cyc();
    finish_run();
  end
endmodule